// File: doc/BRIEF.md
# Software Interrupt Request Register with Level Masking

This block holds a 17-bit software interrupt register and a 4-bit processor interrupt level. It turns the pair into a 17-bit vector of registered interrupt request lines. Software reaches the register through three bus aliases. A plain write replaces the contents. A set alias ORs the written bits in. A clear alias removes the written bits. A fourth bus address holds the interrupt level.

Two hardware inputs mark timer matches. The tick match sets bit 0 and the system timer match sets bit 16. A timer bit raises its request only while the level is below a fixed threshold of 14. Each of bits 1 to 15 raises its request only when its index is strictly above the level. The request vector is recomputed on every change to the register or the level. A request is withdrawn as soon as its condition stops holding. The interrupt logic downstream sees only these request lines.

Top module: `swint_ctrl`

## Requirements
- R1: A bus write to address 0 (direct) stores `bus_wdata[16:0]` into the register. The upper data bits are ignored.
- R2: A bus write to address 1 (set) stores the old register value ORed with `bus_wdata[16:0]`.
- R3: A bus write to address 2 (clear) stores the old register value ANDed with the inverse of `bus_wdata[16:0]`.
- R4: Request bits 0 and 16 are high only when the matching register bit is set and the level is below 14.
- R5: Each request bit i, for i from 1 to 15, is high only when register bit i is set and i is strictly greater than the level.
- R6: `irq_req` reflects the new register and level values from the rising edge that accepts the write. A request falls at that same edge when its condition ends.
- R7: `tick_hit` sets bit 0 and `stick_hit` sets bit 16. When a hit coincides with a bus write, the bus write is applied first and the hit is ORed in afterwards.
- R8: Reading addresses 0, 1 or 2 returns the register zero-extended to 32 bits. Reading address 3 returns the level zero-extended. A write to address 3 stores `bus_wdata[3:0]` as the level.
- R9: Synchronous reset clears the register, sets the level to 15 and drives every request low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | 0 direct, 1 set, 2 clear, 3 level |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational readback selected by `bus_addr` |
| tick_hit | input | 1 | Tick timer match, sets bit 0 |
| stick_hit | input | 1 | System timer match, sets bit 16 |
| irq_req | output | 17 | Registered interrupt request vector |

## Verification
Every write or timer hit is accepted at a rising edge. The new register contents and the new request vector are both due at that edge, with no extra cycle of delay. The driver therefore pushes its expected request vector right after the accepting edge. The monitor compares that vector at the next falling edge. Readback is combinational from registered state, so it is checked at a falling edge shortly after `bus_addr` settles. Randomly mixed aliases, level writes and coinciding timer hits exercise the ordering rule for simultaneous events.

// File: rtl/swint_pkg.sv
package swint_pkg;
  typedef enum logic [1:0] {
    ALIAS_DIRECT = 2'd0,
    ALIAS_SET    = 2'd1,
    ALIAS_CLEAR  = 2'd2,
    ALIAS_LEVEL  = 2'd3
  } swint_alias_e;
endpackage

// File: rtl/swint_store.sv
module swint_store
  import swint_pkg::*;
#(
  parameter int SW_BITS = 17,
  parameter int PIL_W   = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               tick_hit,
  input  logic               stick_hit,
  output logic [SW_BITS-1:0] soft_q,
  output logic [PIL_W-1:0]   pil_q,
  output logic [SW_BITS-1:0] soft_d,
  output logic [PIL_W-1:0]   pil_d
);
  logic [SW_BITS-1:0] wbits;
  logic [SW_BITS-1:0] bus_val;

  assign wbits = wdata[SW_BITS-1:0];

  always_comb begin
    bus_val = soft_q;
    if (wr_en) begin
      case (swint_alias_e'(addr))
        ALIAS_DIRECT: bus_val = wbits;
        ALIAS_SET:    bus_val = soft_q | wbits;
        ALIAS_CLEAR:  bus_val = soft_q & ~wbits;
        default:      bus_val = soft_q;
      endcase
    end
    soft_d = bus_val;
    soft_d[0]         = bus_val[0] | tick_hit;
    soft_d[SW_BITS-1] = bus_val[SW_BITS-1] | stick_hit;
    pil_d = (wr_en && addr == ALIAS_LEVEL) ? wdata[PIL_W-1:0] : pil_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_q <= '0;
      pil_q  <= '1;
    end else begin
      soft_q <= soft_d;
      pil_q  <= pil_d;
    end
  end

  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ALIAS_DIRECT && !tick_hit && !stick_hit)
      |=> soft_q == $past(wbits)); // R1
  AST_SET_ALIAS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ALIAS_SET)
      |=> ((soft_q & $past(soft_q | wbits)) == $past(soft_q | wbits))); // R2
  AST_CLEAR_ALIAS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ALIAS_CLEAR && !tick_hit && !stick_hit)
      |=> ((soft_q & $past(wbits)) == '0)); // R3
  AST_TICK_SET: assert property (@(posedge clk) disable iff (rst)
    tick_hit |=> soft_q[0]); // R7
  AST_STICK_SET: assert property (@(posedge clk) disable iff (rst)
    stick_hit |=> soft_q[SW_BITS-1]); // R7
endmodule

// File: rtl/swint_gate.sv
module swint_gate #(
  parameter int SW_BITS     = 17,
  parameter int PIL_W       = 4,
  parameter int TIMER_LIMIT = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SW_BITS-1:0] soft_d,
  input  logic [PIL_W-1:0]   pil_d,
  output logic [SW_BITS-1:0] irq_q
);
  logic [SW_BITS-1:0] req_c;
  logic               timer_open;

  assign timer_open = (pil_d < PIL_W'(TIMER_LIMIT));

  for (genvar i = 0; i < SW_BITS; i++) begin : g_lvl
    if (i == 0 || i == SW_BITS - 1) begin : g_timer
      assign req_c[i] = soft_d[i] & timer_open;
    end else begin : g_level
      localparam logic [PIL_W:0] IDX = (PIL_W+1)'(i);
      assign req_c[i] = soft_d[i] & (IDX > {1'b0, pil_d});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= req_c;
  end
endmodule

// File: rtl/swint_ctrl.sv
module swint_ctrl
  import swint_pkg::*;
#(
  parameter int SW_BITS     = 17,
  parameter int PIL_W       = 4,
  parameter int DATA_W      = 32,
  parameter int TIMER_LIMIT = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic [1:0]         bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               tick_hit,
  input  logic               stick_hit,
  output logic [SW_BITS-1:0] irq_req
);
  localparam int SOFT_PAD = DATA_W - SW_BITS;
  localparam int PIL_PAD  = DATA_W - PIL_W;

  logic [SW_BITS-1:0] soft_q, soft_d;
  logic [PIL_W-1:0]   pil_q, pil_d;

  swint_store #(.SW_BITS(SW_BITS), .PIL_W(PIL_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .tick_hit(tick_hit), .stick_hit(stick_hit),
    .soft_q(soft_q), .pil_q(pil_q), .soft_d(soft_d), .pil_d(pil_d)
  );

  swint_gate #(.SW_BITS(SW_BITS), .PIL_W(PIL_W), .TIMER_LIMIT(TIMER_LIMIT)) u_gate (
    .clk(clk), .rst(rst), .soft_d(soft_d), .pil_d(pil_d), .irq_q(irq_req)
  );

  always_comb begin
    if (bus_addr == ALIAS_LEVEL) bus_rdata = {{PIL_PAD{1'b0}}, pil_q};
    else                         bus_rdata = {{SOFT_PAD{1'b0}}, soft_q};
  end

  AST_TIMER_GATE: assert property (@(posedge clk) disable iff (rst)
    (pil_q >= PIL_W'(TIMER_LIMIT)) |-> (!irq_req[0] && !irq_req[SW_BITS-1])); // R4
  AST_IRQ_SUBSET: assert property (@(posedge clk) disable iff (rst)
    ((irq_req & ~soft_q) == '0)); // R5
  for (genvar k = 1; k < SW_BITS - 1; k++) begin : g_chk
    localparam logic [PIL_W:0] KIDX = (PIL_W+1)'(k);
    AST_LEVEL_GATE: assert property (@(posedge clk) disable iff (rst)
      (KIDX <= {1'b0, pil_q}) |-> !irq_req[k]); // R5
  end
endmodule

// File: tb/swint_ctrl_tb.sv
`timescale 1ns/1ps
module swint_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_hit = 1'b0;
  logic        stick_hit = 1'b0;
  logic [16:0] irq_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [16:0] m_reg = '0;
  logic [3:0]  m_pil = 4'hF;

  logic [16:0] exp_q[$];
  string       tag_q[$];
  logic [16:0] mon_e;
  string       mon_t;

  always #2.5 clk = ~clk;

  swint_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_hit(tick_hit), .stick_hit(stick_hit), .irq_req(irq_req)
  );

  function automatic logic [16:0] want_irq(logic [16:0] r, logic [3:0] p);
    logic [16:0] v;
    for (int i = 0; i < 17; i++) begin
      if (i == 0 || i == 16) v[i] = r[i] && (p < 4'd14); // R4
      else                   v[i] = r[i] && (i > int'(p)); // R5
    end
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      mon_t = tag_q.pop_front();
      check(irq_req == mon_e, mon_t, {15'd0, irq_req}, {15'd0, mon_e});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input bit tk, input bit st, input string tag);
    logic [16:0] nv;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_hit = tk; stick_hit = st;
    @(posedge clk);
    nv = m_reg;
    case (a)
      2'd0: nv = d[16:0];
      2'd1: nv = m_reg | d[16:0];
      2'd2: nv = m_reg & ~d[16:0];
      default: m_pil = d[3:0];
    endcase
    nv[0]  = nv[0] | tk;
    nv[16] = nv[16] | st;
    m_reg = nv;
    exp_q.push_back(want_irq(m_reg, m_pil));
    tag_q.push_back(tag);
    #1;
    bus_wr = 1'b0; tick_hit = 1'b0; stick_hit = 1'b0;
  endtask

  task automatic rd_check(input logic [1:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    bus_addr = a;
    #1;
    e = (a == 2'd3) ? {28'd0, m_pil} : {15'd0, m_reg};
    check(bus_rdata == e, tag, bus_rdata, e);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(irq_req == '0, "R9 irq after reset", {15'd0, irq_req}, 32'd0);
    rd_check(2'd0, "R9 reg after reset");
    rd_check(2'd3, "R9 level after reset is 15");

    wr(2'd3, 32'h0, 0, 0, "R8 level write 0");
    wr(2'd0, 32'hFFFF_FFFF, 0, 0, "R1 direct write all ones");
    rd_check(2'd1, "R8 readback via set alias");
    rd_check(2'd2, "R8 readback via clear alias");
    wr(2'd3, 32'hE, 0, 0, "R4 level 14 masks timer bits");
    wr(2'd3, 32'hD, 0, 0, "R4 level 13 opens timer bits");
    wr(2'd3, 32'h7, 0, 0, "R5 level 7 boundary");
    rd_check(2'd3, "R8 level readback");
    wr(2'd2, 32'h0000_C081, 0, 0, "R3 clear alias");
    wr(2'd1, 32'h0001_0003, 0, 0, "R2 set alias");
    wr(2'd3, 32'hF, 0, 0, "R6 requests withdrawn at level 15");
    wr(2'd0, 32'h0, 1, 1, "R7 direct write with both hits");
    rd_check(2'd0, "R7 hits ORed after write");
    wr(2'd3, 32'h5, 0, 0, "R6 level drop raises timer requests");
    wr(2'd2, 32'h1_FFFF, 1, 0, "R7 clear with tick keeps bit 0");
    rd_check(2'd0, "R7 readback after clear plus tick");
    wr(2'd1, 32'hFFFE_0000, 0, 0, "R1 upper data bits ignored");
    rd_check(2'd0, "R1 readback unchanged by upper bits");

    for (int n = 0; n < 60; n++) begin
      wr(2'($urandom_range(0, 3)), $urandom, bit'($urandom_range(0, 1)),
         bit'($urandom_range(0, 1)), "R6 random mix");
      if (n % 5 == 0) rd_check(2'($urandom_range(0, 3)), "R8 random readback");
    end
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule